// File: doc/BRIEF.md
# MDIO Clause-22/45 Management Master

This block is the master end of a two-wire PHY management link. It generates the management clock (MDC) from the system clock through a programmable divider. It then shifts frames onto the bidirectional data line (MDIO) through a separate output value and output enable, so that the pad can be tri-stated.

A request comes in on a one-cycle command port. The port carries a 2-bit operation code, a PHY address, a 5-bit register number (clause 22) or device address (clause 45), a 16-bit register address, and write data. A clause-22 request produces one frame. A clause-45 request produces two frames: an address frame, then a read or write frame to the same PHY and device. Every frame is a run of ones followed by a 32-bit word sent most-significant bit first. On read frames the master lets go of the line during the turnaround and shifts the PHY's 16 data bits into a read-data register.

The end of the access is marked by a one-cycle done pulse. If a frame does not finish within a programmable number of MDC periods, the sequence is abandoned and a one-cycle timeout pulse is raised instead.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Operation codes on `cmd_op`: 00 clause-22 read, 01 clause-22 write, 10 clause-45 read, 11 clause-45 write. A clause-22 access sends a single 32-bit word, MSB first, laid out as follows:
  - bits 31:30 start code 01
  - bits 29:28 opcode, 10 for read and 01 for write
  - bits 27:23 PHY address
  - bits 22:18 the 5-bit register number from `cmd_dev`
  - bits 17:16 turnaround 10
  - bits 15:0 write data, or 0 on a read
- R2: Every frame is preceded by exactly 32 driven ones on MDIO.
- R3: A clause-45 access sends two frames with start code 00 and the same PHY and device address in bits 22:18. The address frame has opcode 00 and carries `cmd_reg` in bits 15:0. It is followed by a data frame with opcode 01 and `cmd_wdata` for a write, or opcode 11 for a read.
- R4: On a read frame the master drives only the preamble and frame bits 31 down to 17, releases MDIO from bit 16 onward, and leaves the 16 bits the PHY returns in `rd_data`, MSB first, after the access.
- R5: MDIO value and enable change only in the cycle after an MDC falling edge (or on a timeout abort), so they are stable across each MDC rising edge.
- R6: MDC is a square wave whose period is 2*(`cfg_div_half`+1) system clock cycles.
- R7: `busy` rises the cycle after a command is accepted and stays high until the last bit of the last frame. `done` is a one-cycle pulse in the first cycle with `busy` low.
- R8: A command presented while `busy` is high is ignored: it produces no frame and no extra `done`.
- R9: If a frame has not completed after `cfg_timeout` MDC rising edges, the master pulses `timeout_err` instead of `done`, returns to idle and releases MDIO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle request strobe |
| cmd_op | input | 2 | Operation code (R1) |
| cmd_phy | input | 5 | PHY address |
| cmd_dev | input | 5 | Register number (clause 22) or device address (clause 45) |
| cmd_reg | input | 16 | Clause-45 register address |
| cmd_wdata | input | 16 | Write data |
| cfg_div_half | input | DIV_W | MDC half period minus one, in system clocks |
| cfg_timeout | input | TO_W | Frame time limit in MDC periods |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access completed pulse |
| timeout_err | output | 1 | Access aborted pulse |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench watches the line as a PHY would and decodes every driven bit, so a wrong start code or opcode, or a clause-45 address frame that is missing or in the wrong order, shows up as a bit mismatch. The boundary where the read turnaround begins is checked by counting driven bits. A release one bit late would add a driven bit and fight the PHY, and one bit early would shift the captured data by one place. A command strobed in the middle of an access would, if accepted, add a second frame or a second done pulse. A frame cut short by a small time limit must end with the line released and no done pulse, and a design that left the enable high or still reported completion would be caught there.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADDR = 2'd1,
    SEQ_DATA = 2'd2
  } seq_state_e;

  // cmd_op bit 1 selects clause 45, bit 0 selects write
  function automatic logic [31:0] mdio_build_word(
    input logic        c45,
    input logic        wr,
    input logic        addr_stage,
    input logic [4:0]  phy,
    input logic [4:0]  dev,
    input logic [15:0] regaddr,
    input logic [15:0] wdata
  );
    logic [1:0]  st;
    logic [1:0]  op;
    logic [15:0] dat;
    st = c45 ? 2'b00 : 2'b01;
    if (addr_stage)  op = 2'b00;
    else if (wr)     op = 2'b01;
    else             op = c45 ? 2'b11 : 2'b10;
    if (addr_stage)  dat = regaddr;
    else if (wr)     dat = wdata;
    else             dat = 16'h0000;
    return {st, op, phy, dev, 2'b10, dat};
  endfunction

endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_half,
  output logic             mdc,
  output logic             wrap,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt;

  assign wrap    = (cnt >= div_half);
  assign rise_ev = wrap & ~mdc;
  assign fall_ev = wrap & mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int PRE_LEN = 32,
  localparam int SEQ_LEN = PRE_LEN + 32,
  localparam int IDX_W = $clog2(SEQ_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [31:0]      word,
  input  logic             is_rd,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             frame_done,
  output logic             active,
  output logic             launched,
  output logic             rd_q,
  output logic [IDX_W-1:0] bit_idx,
  output logic [15:0]      rd_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(SEQ_LEN - 17);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(SEQ_LEN - 16);

  logic [SEQ_LEN-1:0] shreg;
  logic [IDX_W-1:0]   next_idx;
  logic               sample_ev;

  assign frame_done = active & launched & rise_ev & (bit_idx == LAST_IDX);
  assign next_idx   = launched ? bit_idx + IDX_W'(1) : '0;
  assign sample_ev  = active & launched & rise_ev & rd_q & (bit_idx >= DATA_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (sample_ev) begin
      rd_data <= {rd_data[14:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      active   <= 1'b0;
      launched <= 1'b0;
      rd_q     <= 1'b0;
      bit_idx  <= '0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
    end else if (abort) begin
      active   <= 1'b0;
      launched <= 1'b0;
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b0;
    end else if (start) begin
      shreg    <= {{PRE_LEN{1'b1}}, word};
      active   <= 1'b1;
      launched <= 1'b0;
      rd_q     <= is_rd;
    end else if (frame_done) begin
      active   <= 1'b0;
      launched <= 1'b0;
    end else if (fall_ev) begin
      if (active) begin
        mdio_o   <= shreg[SEQ_LEN-1];
        shreg    <= shreg << 1;
        bit_idx  <= next_idx;
        launched <= 1'b1;
        mdio_oe  <= ~(rd_q & (next_idx >= REL_IDX));
      end else begin
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int DIV_W   = 8,
  parameter int TO_W    = 16,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [4:0]       cmd_phy,
  input  logic [4:0]       cmd_dev,
  input  logic [15:0]      cmd_reg,
  input  logic [15:0]      cmd_wdata,
  input  logic [DIV_W-1:0] cfg_div_half,
  input  logic [TO_W-1:0]  cfg_timeout,
  output logic             busy,
  output logic             done,
  output logic             timeout_err,
  output logic [15:0]      rd_data,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  import mdio_pkg::*;

  localparam int IDX_W = $clog2(PRE_LEN + 32);

  seq_state_e       state;
  logic [1:0]       op_q;
  logic [4:0]       phy_q, dev_q;
  logic [15:0]      reg_q, wdata_q;
  logic [TO_W-1:0]  to_cnt;

  logic             wrap, rise_ev, fall_ev;
  logic             accept, start_frame, frame_done, expire;
  logic             eng_active, eng_launched, eng_rd, start_rd;
  logic [IDX_W-1:0] bit_idx;
  logic [31:0]      word;

  assign accept      = (state == SEQ_IDLE) & cmd_valid;
  assign start_frame = accept | ((state == SEQ_ADDR) & frame_done);
  assign busy        = (state != SEQ_IDLE);

  always_comb begin
    if (accept) begin
      word     = mdio_build_word(cmd_op[1], cmd_op[0], cmd_op[1],
                                 cmd_phy, cmd_dev, cmd_reg, cmd_wdata);
      start_rd = ~cmd_op[1] & ~cmd_op[0];
    end else begin
      word     = mdio_build_word(op_q[1], op_q[0], 1'b0,
                                 phy_q, dev_q, reg_q, wdata_q);
      start_rd = ~op_q[0];
    end
  end

  assign expire = busy & eng_active & rise_ev & ~frame_done &
                  (({1'b0, to_cnt} + {{TO_W{1'b0}}, 1'b1}) >= {1'b0, cfg_timeout});

  mdio_mdc_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_half(cfg_div_half),
    .mdc(mdc), .wrap(wrap), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_frame), .abort(expire),
    .word(word), .is_rd(start_rd), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .frame_done(frame_done), .active(eng_active), .launched(eng_launched),
    .rd_q(eng_rd), .bit_idx(bit_idx), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_cnt <= '0;
    end else if (start_frame) begin
      to_cnt <= '0;
    end else if (eng_active & rise_ev) begin
      to_cnt <= to_cnt + TO_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SEQ_IDLE;
      op_q        <= '0;
      phy_q       <= '0;
      dev_q       <= '0;
      reg_q       <= '0;
      wdata_q     <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done        <= 1'b0;
      timeout_err <= 1'b0;
      if (expire) begin
        state       <= SEQ_IDLE;
        timeout_err <= 1'b1;
      end else begin
        case (state)
          SEQ_IDLE: if (accept) begin
            op_q    <= cmd_op;
            phy_q   <= cmd_phy;
            dev_q   <= cmd_dev;
            reg_q   <= cmd_reg;
            wdata_q <= cmd_wdata;
            state   <= cmd_op[1] ? SEQ_ADDR : SEQ_DATA;
          end
          SEQ_ADDR: if (frame_done) state <= SEQ_DATA;
          SEQ_DATA: if (frame_done) begin
            state <= SEQ_IDLE;
            done  <= 1'b1;
          end
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
  parameter int IDX_W = 6,
  parameter int PRE_LEN = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mdc,
  input logic             wrap,
  input logic             fall_ev,
  input logic             abort,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic             done,
  input logic             timeout_err,
  input logic             eng_rd,
  input logic             eng_launched,
  input logic [IDX_W-1:0] bit_idx
);
  localparam logic [IDX_W-1:0] REL_IDX = IDX_W'(PRE_LEN + 32 - 17);

  a_r5_mdio_moves_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fall_ev) && !$past(abort)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r6_mdc_toggles_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc) |-> $past(wrap));

  a_r4_read_line_released: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_launched && eng_rd && (bit_idx >= REL_IDX)) |-> !mdio_oe);

  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_busy_ends_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || timeout_err));

  a_r9_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (!mdio_oe && !done));
endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(.IDX_W(IDX_W), .PRE_LEN(PRE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .wrap(wrap), .fall_ev(fall_ev),
  .abort(expire), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy),
  .done(done), .timeout_err(timeout_err), .eng_rd(eng_rd),
  .eng_launched(eng_launched), .bit_idx(bit_idx)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  localparam logic [1:0] C22_RD = 2'b00, C22_WR = 2'b01, C45_RD = 2'b10, C45_WR = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [4:0] cmd_phy = '0, cmd_dev = '0;
  logic [15:0] cmd_reg = '0, cmd_wdata = '0;
  logic [7:0] cfg_div_half = 8'd2;
  logic [15:0] cfg_timeout = 16'd200;
  logic busy, done, timeout_err, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i;

  int checks = 0, failures = 0;
  logic cap [0:511];
  int cap_n = 0;
  int n_done = 0, n_err = 0;
  logic [15:0] phy_pat = '0;
  int rdk = 0;
  logic mdc_prev = 1'b0;
  int since_rise = 0, last_period = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mdio_mgmt_master u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_phy(cmd_phy), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .cfg_div_half(cfg_div_half),
    .cfg_timeout(cfg_timeout), .busy(busy), .done(done),
    .timeout_err(timeout_err), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY-side observer and responder, acting between clock edges
  always @(negedge clk) begin
    if (!rst_n) begin
      mdio_i = 1'b1;
      mdc_prev = 1'b0;
    end else begin
      if (done) n_done++;
      if (timeout_err) n_err++;
      since_rise++;
      if (mdc && !mdc_prev) begin
        last_period = since_rise;
        since_rise = 0;
        if (mdio_oe && cap_n < 512) begin
          cap[cap_n] = mdio_o;
          cap_n++;
        end
      end
      if (!mdc && mdc_prev) begin
        if (mdio_oe) begin
          rdk = 0;
          mdio_i = 1'b1;
        end else begin
          if (rdk == 0) mdio_i = 1'b0;
          else if (rdk <= 16) mdio_i = phy_pat[16-rdk];
          else mdio_i = 1'b1;
          rdk++;
        end
      end
      mdc_prev = mdc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] phy, input logic [4:0] dev, input logic [15:0] dat);
    logic [31:0] w;
    w = '0;
    w[31:30] = st; w[29:28] = op; w[27:23] = phy;
    w[22:18] = dev; w[17:16] = 2'b10; w[15:0] = dat;
    return w;
  endfunction

  // compare captured bits at offset: 32 ones then nb bits of w, MSB first
  task automatic chk_frame(input int off, input logic [31:0] w, input int nb,
                           input string req);
    int bad = -1;
    for (int i = 0; i < 32 + nb; i++) begin
      logic e;
      e = (i < 32) ? 1'b1 : w[31-(i-32)];
      if (bad < 0 && (off + i >= cap_n || cap[off+i] !== e)) bad = i;
    end
    chk(bad < 0, req, "frame bit mismatch at index", bad, -1);
  endtask

  task automatic issue(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] dev,
                       input logic [15:0] ra, input logic [15:0] wd);
    @(negedge clk);
    cmd_op = op; cmd_phy = phy; cmd_dev = dev; cmd_reg = ra; cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 8000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_obs();
    cap_n = 0; n_done = 0; n_err = 0;
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R7", "busy after reset", busy, 0);
    chk(done == 1'b0, "R7", "done after reset", done, 0);
    chk(timeout_err == 1'b0, "R9", "timeout after reset", timeout_err, 0);
    chk(mdio_oe == 1'b0, "R4", "oe after reset", mdio_oe, 0);
    chk(rd_data == 16'h0, "R4", "rd_data after reset", rd_data, 0);
  endtask

  task automatic t_c22_write();
    clear_obs();
    issue(C22_WR, 5'h11, 5'h04, 16'h0, 16'hA5C3);
    chk(busy == 1'b1, "R7", "busy after accept", busy, 1);
    wait_idle();
    chk(cap_n == 64, "R2", "driven bits c22 write", cap_n, 64);
    chk_frame(0, exp_word(2'b01, 2'b01, 5'h11, 5'h04, 16'hA5C3), 32, "R1");
    chk(n_done == 1, "R7", "done pulses", n_done, 1);
  endtask

  task automatic t_c22_read();
    clear_obs();
    phy_pat = 16'h9E21;
    issue(C22_RD, 5'h03, 5'h1F, 16'h0, 16'hFFFF);
    wait_idle();
    chk(cap_n == 47, "R4", "driven bits c22 read", cap_n, 47);
    chk_frame(0, exp_word(2'b01, 2'b10, 5'h03, 5'h1F, 16'h0), 15, "R1");
    chk(rd_data == 16'h9E21, "R4", "c22 read data", rd_data, 16'h9E21);
    chk(n_done == 1, "R7", "done pulses", n_done, 1);
  endtask

  task automatic t_c45_write();
    clear_obs();
    issue(C45_WR, 5'h0A, 5'h07, 16'h8012, 16'h3C5A);
    wait_idle();
    chk(cap_n == 128, "R3", "driven bits c45 write", cap_n, 128);
    chk_frame(0, exp_word(2'b00, 2'b00, 5'h0A, 5'h07, 16'h8012), 32, "R3");
    chk_frame(64, exp_word(2'b00, 2'b01, 5'h0A, 5'h07, 16'h3C5A), 32, "R3");
    chk(n_done == 1, "R7", "done pulses c45", n_done, 1);
  endtask

  task automatic t_c45_read();
    clear_obs();
    phy_pat = 16'h5A0F;
    issue(C45_RD, 5'h1E, 5'h01, 16'hFFFE, 16'h1234);
    wait_idle();
    chk(cap_n == 111, "R4", "driven bits c45 read", cap_n, 111);
    chk_frame(0, exp_word(2'b00, 2'b00, 5'h1E, 5'h01, 16'hFFFE), 32, "R3");
    chk_frame(64, exp_word(2'b00, 2'b11, 5'h1E, 5'h01, 16'h0), 15, "R3");
    chk(rd_data == 16'h5A0F, "R4", "c45 read data", rd_data, 16'h5A0F);
  endtask

  task automatic t_ignore_busy();
    clear_obs();
    issue(C22_WR, 5'h01, 5'h02, 16'h0, 16'h00FF);
    repeat (50) @(negedge clk);
    issue(C22_RD, 5'h07, 5'h09, 16'h0, 16'h0);
    wait_idle();
    repeat (1000) @(negedge clk);
    chk(cap_n == 64, "R8", "driven bits with busy command", cap_n, 64);
    chk_frame(0, exp_word(2'b01, 2'b01, 5'h01, 5'h02, 16'h00FF), 32, "R8");
    chk(n_done == 1, "R8", "done pulses with busy command", n_done, 1);
    chk(busy == 1'b0, "R8", "busy after ignored command", busy, 0);
  endtask

  task automatic t_timeout();
    clear_obs();
    cfg_timeout = 16'd10;
    issue(C45_WR, 5'h02, 5'h03, 16'h4444, 16'h5555);
    wait_idle();
    chk(n_err == 1, "R9", "timeout pulses", n_err, 1);
    chk(n_done == 0, "R9", "done pulses on timeout", n_done, 0);
    chk(cap_n < 64, "R9", "driven bits on timeout", cap_n, 63);
    chk(mdio_oe == 1'b0, "R9", "oe after timeout", mdio_oe, 0);
    cfg_timeout = 16'd200;
    clear_obs();
    issue(C22_WR, 5'h04, 5'h05, 16'h0, 16'hBEEF);
    wait_idle();
    chk(n_done == 1 && cap_n == 64, "R9", "recovery after timeout", cap_n, 64);
  endtask

  task automatic t_mdc_period();
    cfg_div_half = 8'd2;
    repeat (40) @(negedge clk);
    chk(last_period == 6, "R6", "mdc period div 2", last_period, 6);
    cfg_div_half = 8'd5;
    repeat (60) @(negedge clk);
    chk(last_period == 12, "R6", "mdc period div 5", last_period, 12);
    cfg_div_half = 8'd2;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mdc_period();
    t_c22_write();
    t_c22_read();
    t_c45_write();
    t_c45_read();
    t_ignore_busy();
    t_timeout();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule